// File: doc/BRIEF.md
# Wide-Bus CRC-32 Engine with Byte-Granular Packet End

This block computes a 32-bit cyclic redundancy check over packets delivered on a 64-bit bus, one word per accepted beat. The first byte of the packet sits in the most significant lane of the first word. The final word of a packet may carry any number of valid bytes from one to eight, always packed toward the most significant lane. The engine keeps a running remainder across the body of the packet. When the final beat arrives, it combines that remainder with the last two words and finishes the checksum in a single wide step. It does not need a separate network for every possible ending lane.

To finish a packet, the running remainder is folded by XOR into the top 32 bits of the second-to-last word. The two tail words are then joined and shifted right so that the final valid byte lands in the least significant lane. The unused lanes become leading zeros. A zero-seeded CRC step over those 128 bits then gives the result. Because the step starts from zero, the leading zeros do not change the remainder. The checksum is registered and announced with a one-cycle strobe.

Top module: `wide_crc_engine`

## Requirements
- R1: The checksum uses generator polynomial 0x04C11DB7 with the register preset to 0xFFFFFFFF. It processes every byte most significant bit first, with no bit reflection and no final inversion. The nine ASCII bytes "123456789" therefore give 0x0376E6E7.
- R2: Bytes are taken in this order: in_data[63:56] first, down to in_data[7:0], and words in the order they are accepted.
- R3: On the end-of-packet beat, in_nbytes (1 to 8) gives the number of valid bytes in that word. They occupy the top lanes, from in_data[63:56] downward. A packet may end at any of the eight lanes.
- R4: The content of the lanes below the valid count on the end-of-packet beat has no effect on crc_out.
- R5: crc_done is high for exactly one cycle, starting at the second rising edge after the end-of-packet beat is presented. At all other times it is low.
- R6: crc_out changes only together with a crc_done pulse and otherwise holds the last result.
- R7: Cycles with in_valid low are ignored, whatever in_data, in_sop and in_eop carry during them. They may occur between any two beats of a packet.
- R8: A start-of-packet beat may directly follow an end-of-packet beat, and both packets are checked correctly.
- R9: A packet is at least 9 bytes long (two or more beats). in_sop marks its first beat and in_eop its last. A packet of exactly two beats uses the preset value as the prior remainder.
- R10: While rst_n is low and after its release, crc_done is 0 and crc_out is 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 64 | Packet word, first byte in the top lane |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_nbytes | input | 4 | Valid byte count on the last beat (1 to 8) |
| crc_out | output | 32 | Registered checksum |
| crc_done | output | 1 | One-cycle strobe marking a new checksum |

## Verification
The hardest situation to reach is the combination of every ending lane with every prior-remainder source. That means two-beat packets that never update the running state, and longer ones that do. It also includes gaps that hold the one-word lookahead across idle cycles. The stimulus sweeps packet lengths from 9 to 40 bytes, so each of the eight lanes is hit with both state sources. It repeats the sweep with random idle cycles that carry random control flags, and again back to back. The unused lanes are filled with random bytes, and some payloads are replayed with zero fill to show that those lanes have no effect.

// File: rtl/wcrc_pkg.sv
package wcrc_pkg;
   localparam int unsigned BYTE_W         = 8;
   localparam logic [31:0] CRC32_POLY     = 32'h04C1_1DB7;
   localparam logic [31:0] CRC32_SEED     = 32'hFFFF_FFFF;
   localparam int unsigned DEF_DATA_W     = 64;
   localparam int unsigned DEF_CRC_W      = 32;
endpackage

// File: rtl/wcrc_feed_net.sv
// Combinational CRC advance: shifts DATA_W message bits, MSB first,
// through a CRC_W remainder starting from state_in.
module wcrc_feed_net #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CRC_W  = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
   input  logic [CRC_W-1:0]  state_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  state_out
);
   always_comb begin
      logic [CRC_W-1:0] rem;
      logic             fb;
      rem = state_in;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = rem[CRC_W-1] ^ data_in[i];
         rem = {rem[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      state_out = rem;
   end
endmodule

// File: rtl/wcrc_accum.sv
// Running remainder over every word except the last two, with a
// one-word lookahead so the second-to-last word is still held at eop.
module wcrc_accum #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CRC_W  = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] SEED = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic              beat_sop,
   input  logic              beat_eop,
   input  logic [DATA_W-1:0] beat_data,
   output logic [CRC_W-1:0]  prior_state,
   output logic [DATA_W-1:0] held_word
);
   logic [CRC_W-1:0]  run_state;
   logic [CRC_W-1:0]  next_state;
   logic              use_seed;
   logic              have_word;

   assign prior_state = use_seed ? SEED : run_state;

   wcrc_feed_net #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) body_net_i (
      .state_in  (prior_state),
      .data_in   (held_word),
      .state_out (next_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_state <= '0;
         use_seed  <= 1'b1;
         held_word <= '0;
         have_word <= 1'b0;
      end else if (beat_valid) begin
         if (beat_sop) begin
            held_word <= beat_data;
            have_word <= 1'b1;
            use_seed  <= 1'b1;
         end else if (beat_eop) begin
            have_word <= 1'b0;
         end else begin
            run_state <= next_state;
            use_seed  <= 1'b0;
            held_word <= beat_data;
         end
      end
   end

   // R9: an end beat always closes a packet that already holds a word
   p_eop_after_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_eop) |-> (have_word && !beat_sop))
      else $error("eop without a preceding packet word");

   // R9: a body beat that is not the first never consumes the seed twice
   p_seed_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_sop && !beat_eop) |=> !use_seed)
      else $error("seed still selected after a body word");
endmodule

// File: rtl/wcrc_tail_align.sv
// Folds the prior remainder into the tail, masks unused lanes of the
// final word and right-aligns the tail so the last valid byte is lowest.
module wcrc_tail_align #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned CNT_W  = 4
) (
   input  logic [CRC_W-1:0]    prior_state,
   input  logic [DATA_W-1:0]   held_word,
   input  logic [DATA_W-1:0]   last_word,
   input  logic [CNT_W-1:0]    nbytes,
   output logic [2*DATA_W-1:0] aligned,
   output logic [CNT_W-1:0]    lanes_used
);
   localparam int unsigned LANES = DATA_W / wcrc_pkg::BYTE_W;
   localparam int unsigned SH_W  = $clog2(2 * DATA_W) + 1;

   logic [DATA_W-1:0]   keep_mask;
   logic [DATA_W-1:0]   folded_hi;
   logic [2*DATA_W-1:0] joined;
   logic [SH_W-1:0]     shamt;

   // zero or out-of-range counts mean a full word
   assign lanes_used = (nbytes == '0 || nbytes > CNT_W'(LANES)) ? CNT_W'(LANES) : nbytes;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign keep_mask[DATA_W-1-wcrc_pkg::BYTE_W*l -: wcrc_pkg::BYTE_W] =
         (CNT_W'(l) < lanes_used) ? '1 : '0;
   end

   if (DATA_W > CRC_W) begin : g_fold_part
      assign folded_hi = held_word ^ {prior_state, {(DATA_W-CRC_W){1'b0}}};
   end else begin : g_fold_full
      assign folded_hi = held_word ^ prior_state;
   end

   assign joined  = {folded_hi, last_word & keep_mask};
   assign shamt   = SH_W'((LANES - int'(lanes_used)) * wcrc_pkg::BYTE_W);
   assign aligned = joined >> shamt;
endmodule

// File: rtl/wide_crc_engine.sv
module wide_crc_engine #(
   parameter int unsigned DATA_W = wcrc_pkg::DEF_DATA_W,
   parameter int unsigned CRC_W  = wcrc_pkg::DEF_CRC_W,
   parameter logic [CRC_W-1:0] POLY = wcrc_pkg::CRC32_POLY,
   parameter logic [CRC_W-1:0] SEED = wcrc_pkg::CRC32_SEED,
   localparam int unsigned LANES = DATA_W / wcrc_pkg::BYTE_W,
   localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [CNT_W-1:0]  in_nbytes,
   output logic [CRC_W-1:0]  crc_out,
   output logic              crc_done
);
   if (DATA_W % wcrc_pkg::BYTE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a whole number of bytes");
   end
   if (DATA_W < CRC_W) begin : g_bad_tail
      $error("DATA_W must be at least CRC_W for the tail fold");
   end
   if (CRC_W < 2) begin : g_bad_crc
      $error("CRC_W must be at least 2");
   end

   logic [CRC_W-1:0]    prior_state;
   logic [DATA_W-1:0]   held_word;
   logic [2*DATA_W-1:0] aligned;
   logic [CNT_W-1:0]    lanes_used;
   logic [2*DATA_W-1:0] stage_data;
   logic [CNT_W-1:0]    stage_n;
   logic                stage_vld;
   logic [CRC_W-1:0]    tail_crc;

   wcrc_accum #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) accum_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .beat_valid  (in_valid),
      .beat_sop    (in_sop),
      .beat_eop    (in_eop),
      .beat_data   (in_data),
      .prior_state (prior_state),
      .held_word   (held_word)
   );

   wcrc_tail_align #(.DATA_W(DATA_W), .CRC_W(CRC_W), .CNT_W(CNT_W)) align_i (
      .prior_state (prior_state),
      .held_word   (held_word),
      .last_word   (in_data),
      .nbytes      (in_nbytes),
      .aligned     (aligned),
      .lanes_used  (lanes_used)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_data <= '0;
         stage_n    <= '0;
         stage_vld  <= 1'b0;
      end else begin
         stage_vld <= in_valid && in_eop;
         if (in_valid && in_eop) begin
            stage_data <= aligned;
            stage_n    <= lanes_used;
         end
      end
   end

   wcrc_feed_net #(.DATA_W(2*DATA_W), .CRC_W(CRC_W), .POLY(POLY)) tail_net_i (
      .state_in  ('0),
      .data_in   (stage_data),
      .state_out (tail_crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_out  <= '0;
         crc_done <= 1'b0;
      end else begin
         crc_done <= stage_vld;
         if (stage_vld) crc_out <= tail_crc;
      end
   end

   // R5: the strobe follows the end beat after the fixed latency
   p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eop) |=> ##1 crc_done)
      else $error("done strobe missing after end beat");

   // R5: strobe lasts one cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done |=> !crc_done)
      else $error("done strobe longer than one cycle");

   // R6: result holds unless a staged tail is finishing
   p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_vld |=> $stable(crc_out))
      else $error("checksum moved without a staged tail");

   // R3: every lane above the aligned tail is zero
   p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stage_vld |-> ((stage_data >> (DATA_W + wcrc_pkg::BYTE_W * int'(stage_n))) == '0))
      else $error("aligned tail has nonzero leading lanes");
endmodule

// File: tb/wide_crc_engine_tb.sv
`timescale 1ns/1ps
module wide_crc_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic [3:0]  in_nbytes = 4'd8;
   logic [31:0] crc_out;
   logic        crc_done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit running = 1'b0;
   bit finished = 1'b0;
   logic [31:0] last_crc = '0;
   logic [31:0] exp_crc [int];
   string       exp_tag [int];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wide_crc_engine dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .in_nbytes (in_nbytes),
      .crc_out   (crc_out),
      .crc_done  (crc_done)
   );

   function automatic logic [31:0] ref_crc(input byte unsigned pl[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (pl[i]) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb = c[31] ^ pl[i][b];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%08h expected=%08h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (running) begin
         if (exp_crc.exists(cyc)) begin
            check(crc_done === 1'b1, "R5", "done strobe", {31'd0, crc_done}, 32'd1);
            check(crc_out === exp_crc[cyc], exp_tag[cyc], "checksum R1", crc_out, exp_crc[cyc]);
            last_crc = exp_crc[cyc];
            exp_crc.delete(cyc);
            exp_tag.delete(cyc);
         end else begin
            check(crc_done === 1'b0, "R5", "idle strobe", {31'd0, crc_done}, 32'd0);
            check(crc_out === last_crc, "R6", "held checksum", crc_out, last_crc);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk); #1;
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
   endtask

   task automatic send_pkt(input byte unsigned pl[$], input bit gaps,
                           input bit zero_fill, input string tag);
      int nw;
      int rem;
      logic [63:0] wd;
      logic [31:0] e;
      nw = (pl.size() + 7) / 8;
      e  = ref_crc(pl);
      for (int w = 0; w < nw; w++) begin
         if (gaps) begin
            repeat ($urandom_range(0, 2)) begin
               @(posedge clk); #1;
               in_valid = 1'b0; in_sop = 1'($urandom); in_eop = 1'($urandom);
               in_data = {$urandom, $urandom}; in_nbytes = 4'($urandom);
            end
         end
         for (int l = 0; l < 8; l++) begin
            int idx = w * 8 + l;
            wd[63-8*l -: 8] = (idx < pl.size()) ? pl[idx] : (zero_fill ? 8'h00 : 8'($urandom));
         end
         rem = pl.size() - w * 8;
         @(posedge clk); #1;
         in_valid = 1'b1; in_sop = (w == 0); in_eop = (w == nw - 1);
         in_nbytes = (w == nw - 1) ? 4'(rem) : 4'd8;
         in_data = wd;
         if (w == nw - 1) begin
            exp_crc[cyc + 2] = e;
            exp_tag[cyc + 2] = tag;
         end
      end
   endtask

   task automatic rand_payload(input int len, output byte unsigned pl[$]);
      pl = {};
      for (int i = 0; i < len; i++) pl.push_back(8'($urandom));
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      byte unsigned pl[$];
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check(crc_done === 1'b0, "R10", "done in reset", {31'd0, crc_done}, 32'd0);
      check(crc_out === 32'd0, "R10", "crc in reset", crc_out, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(crc_out === 32'd0 && crc_done === 1'b0, "R10", "after release", crc_out, 32'd0);
      running = 1'b1;

      // R1: fixed check value for ASCII "123456789" (two-beat packet, R9)
      pl = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      check(ref_crc(pl) === 32'h0376_E6E7, "R1", "reference model", ref_crc(pl), 32'h0376_E6E7);
      send_pkt(pl, 1'b0, 1'b0, "R1");
      idle(4);

      // R2 R3 R8: lengths 9..40 back to back, every ending lane
      for (int len = 9; len <= 40; len++) begin
         rand_payload(len, pl);
         send_pkt(pl, 1'b0, 1'b0, "R2 R3 R8");
      end
      idle(4);

      // R7: idle cycles with random control flags between beats
      for (int len = 9; len <= 40; len++) begin
         rand_payload(len, pl);
         send_pkt(pl, 1'b1, 1'b0, "R7");
      end
      idle(4);

      // R9: two-beat packets use the preset as prior remainder
      for (int len = 9; len <= 16; len++) begin
         rand_payload(len, pl);
         send_pkt(pl, 1'b0, 1'b0, "R9");
         idle(1);
      end
      idle(4);

      // R4: same payload with zero fill and with random fill in unused lanes
      for (int len = 17; len <= 24; len++) begin
         rand_payload(len, pl);
         send_pkt(pl, 1'b0, 1'b1, "R4");
         send_pkt(pl, 1'b0, 1'b0, "R4");
      end
      idle(6);

      running = 1'b0;
      check(exp_crc.size() == 0, "R5", "missing strobes", 32'(exp_crc.size()), 32'd0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL R5 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule